// File: doc/BRIEF.md
# Scancode to Front-Panel Event Translator

This block sits behind a keyboard receiver. It turns a stream of scancode bytes into events for a small front panel that has two rotary wheels and four push buttons. Each byte arrives with a one-cycle valid. One prefix byte selects a second code map in which the arrow keys turn the wheels. Plain codes press and release the buttons.

Each accepted event leaves three registered outputs. The event vector holds one bit per wheel, per wheel direction and per button. A released level gives the direction of the key. A single-cycle strobe announces the event. The block keeps a pressed or released flag for every event bit. A press of a button that is already held is therefore swallowed, and keyboard auto-repeat cannot flood the consumer with button events. Wheel events are never filtered, so every repeated arrow code moves the wheel again.

Top module: `kpx_scan_panel`

## Requirements
- R1: After reset, `evt_strobe`, `evt_bits` and `evt_released` are all zero, the extended flag is clear, and every event bit is tracked as released. The first press of any button therefore produces an event.
- R2: The byte 0xE0 produces no strobe and leaves the outputs unchanged. It marks the next byte as extended, and a second 0xE0 keeps that mark.
- R3: Bit 7 of a non-prefix byte is the release flag, and bits 6:0 are the key code used for mapping. A strobed event has `evt_released` equal to bit 7 of the byte that caused it.
- R4: In the extended map, key 0x48 gives event 0x0C (navigation wheel plus invert), key 0x50 gives 0x04, key 0x4B gives 0x03 (volume wheel plus invert) and key 0x4D gives 0x01.
- R5: In the plain map, key 0x21 gives 0x10 (favourites), key 0x32 gives 0x20 (menu), key 0x0F gives 0x40 (volume button) and key 0x1C gives 0x80 (navigation button).
- R6: A button press whose event bit is tracked as pressed produces no strobe and leaves the outputs unchanged.
- R7: A release marks its event bits released and drives `evt_released` high. A press marks them pressed and drives `evt_released` low.
- R8: A mapped byte accepted on one clock edge drives `evt_bits` and `evt_released` and raises `evt_strobe` for exactly one cycle after that edge. The vector and the level then hold until the next event.
- R9: Any non-prefix byte clears the extended flag, whether or not it produced an event.
- R10: A code with no entry in the active map produces no strobe and no output change. This covers arrow keys without the prefix and button keys with the prefix.
- R11: Wheel events are never suppressed. Repeated presses of the same arrow key each produce a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| code_valid | input | 1 | Scancode byte present this cycle |
| code_byte | input | 8 | Scancode byte: bit 7 is release, bits 6:0 are the key |
| evt_bits | output | 8 | Event vector of the last event |
| evt_released | output | 1 | Direction of the last event (1 = release) |
| evt_strobe | output | 1 | One-cycle pulse per event |

## Verification
The hardest state to reach is the hold tracker holding a button as pressed while a second press of the same key arrives. It only shows at the ports as a missing strobe. The stimulus presses a button, presses it again, then releases it and presses it once more, so that both the swallowed press and the re-armed one are observed. The extended flag is driven through prefix pairs, double prefixes and prefixes followed by unmapped codes, so that its clearing can be seen on the following plain byte.

// File: rtl/kpx_pkg.sv
package kpx_pkg;
    localparam int EVT_W  = 8;
    localparam int BYTE_W = 8;
    localparam int KEY_W  = BYTE_W - 1;

    // event bit positions
    localparam int EV_VOL_WHL = 0;
    localparam int EV_VOL_INV = 1;
    localparam int EV_NAV_WHL = 2;
    localparam int EV_NAV_INV = 3;
    localparam int EV_FAV_BTN = 4;
    localparam int EV_MNU_BTN = 5;
    localparam int EV_VOL_BTN = 6;
    localparam int EV_NAV_BTN = 7;

    typedef struct packed {
        logic             ext;
        logic [EVT_W-1:0] bits;
        logic             rel;
        logic             stb;
    } kpx_state_t;
endpackage

// File: rtl/kpx_code_map.sv
module kpx_code_map
    import kpx_pkg::*;
(
    input  logic             ext_i,
    input  logic [KEY_W-1:0] key_i,
    output logic [EVT_W-1:0] evt_o,
    output logic             btn_o
);
    always_comb begin
        evt_o = '0;
        if (ext_i) begin
            unique case (key_i)
                7'h48: begin evt_o[EV_NAV_WHL] = 1'b1; evt_o[EV_NAV_INV] = 1'b1; end
                7'h50: evt_o[EV_NAV_WHL] = 1'b1;
                7'h4B: begin evt_o[EV_VOL_WHL] = 1'b1; evt_o[EV_VOL_INV] = 1'b1; end
                7'h4D: evt_o[EV_VOL_WHL] = 1'b1;
                default: evt_o = '0;
            endcase
        end else begin
            unique case (key_i)
                7'h21: evt_o[EV_FAV_BTN] = 1'b1;
                7'h32: evt_o[EV_MNU_BTN] = 1'b1;
                7'h0F: evt_o[EV_VOL_BTN] = 1'b1;
                7'h1C: evt_o[EV_NAV_BTN] = 1'b1;
                default: evt_o = '0;
            endcase
        end
        btn_o = |evt_o[EV_NAV_BTN:EV_FAV_BTN];
    end
endmodule

// File: rtl/kpx_hold_track.sv
module kpx_hold_track #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         upd_i,
    input  logic         rel_i,
    input  logic [W-1:0] evt_i,
    output logic [W-1:0] free_o
);
    logic [W-1:0] free_d, free_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            free_d[i] = free_q[i];
            if (upd_i && evt_i[i]) free_d[i] = rel_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) free_q <= '1;
        else        free_q <= free_d;
    end

    assign free_o = free_q;
endmodule

// File: rtl/kpx_scan_panel.sv
module kpx_scan_panel
    import kpx_pkg::*;
#(
    parameter logic [BYTE_W-1:0] PREFIX = 8'hE0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              code_valid,
    input  logic [BYTE_W-1:0] code_byte,
    output logic [EVT_W-1:0]  evt_bits,
    output logic              evt_released,
    output logic              evt_strobe
);
    kpx_state_t st_d, st_q;

    logic [EVT_W-1:0] map_evt;
    logic             map_btn;
    logic [EVT_W-1:0] free_bits;
    logic             is_prefix, is_rel, blocked, fire;

    kpx_code_map u_map (
        .ext_i (st_q.ext),
        .key_i (code_byte[KEY_W-1:0]),
        .evt_o (map_evt),
        .btn_o (map_btn)
    );

    kpx_hold_track #(.W(EVT_W)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .upd_i  (fire),
        .rel_i  (is_rel),
        .evt_i  (map_evt),
        .free_o (free_bits)
    );

    always_comb begin
        is_prefix = (code_byte == PREFIX);
        is_rel    = code_byte[BYTE_W-1];
        blocked   = map_btn && !is_rel && ((map_evt & free_bits) == '0);
        fire      = code_valid && !is_prefix && (map_evt != '0) && !blocked;

        st_d     = st_q;
        st_d.stb = 1'b0;
        if (code_valid) begin
            st_d.ext = is_prefix;
            if (fire) begin
                st_d.bits = map_evt;
                st_d.rel  = is_rel;
                st_d.stb  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign evt_bits     = st_q.bits;
    assign evt_released = st_q.rel;
    assign evt_strobe   = st_q.stb;
endmodule

// File: rtl/kpx_scan_panel_chk.sv
module kpx_scan_panel_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       code_valid,
    input logic [7:0] code_byte,
    input logic [7:0] evt_bits,
    input logic       evt_released,
    input logic       evt_strobe
);
    AST_STROBE_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_strobe |-> $past(code_valid)); // R8
    AST_PREFIX_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (code_valid && code_byte == 8'hE0) |=> !evt_strobe); // R2
    AST_REL_FROM_BIT7: assert property (@(posedge clk) disable iff (!rst_n)
        evt_strobe |-> (evt_released == $past(code_byte[7]))); // R3
    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_strobe |-> ($stable(evt_bits) && $stable(evt_released))); // R10
    AST_EVENT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        evt_strobe |-> (evt_bits != 8'h00)); // R10
    AST_BUTTON_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_strobe && evt_bits[7:4] != 4'h0) |-> ($onehot0(evt_bits) && evt_bits[3:0] == 4'h0)); // R5
endmodule

bind kpx_scan_panel kpx_scan_panel_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .code_valid   (code_valid),
    .code_byte    (code_byte),
    .evt_bits     (evt_bits),
    .evt_released (evt_released),
    .evt_strobe   (evt_strobe)
);

// File: tb/sim_kpx_scan_panel.sv
module sim_kpx_scan_panel;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       code_valid = 1'b0;
    logic [7:0] code_byte = 8'h00;
    logic [7:0] evt_bits;
    logic       evt_released;
    logic       evt_strobe;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    bit       m_ext = 0;
    bit [7:0] m_free = 8'hFF;
    bit [7:0] e_bits = 0;
    bit       e_rel = 0;
    bit       e_stb = 0;

    kpx_scan_panel u0 (
        .clk(clk), .rst_n(rst_n), .code_valid(code_valid), .code_byte(code_byte),
        .evt_bits(evt_bits), .evt_released(evt_released), .evt_strobe(evt_strobe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int ref_map(bit ext, int key);
        if (ext) begin
            if (key == 'h48) return 'h0C;
            if (key == 'h50) return 'h04;
            if (key == 'h4B) return 'h03;
            if (key == 'h4D) return 'h01;
        end else begin
            if (key == 'h21) return 'h10;
            if (key == 'h32) return 'h20;
            if (key == 'h0F) return 'h40;
            if (key == 'h1C) return 'h80;
        end
        return 0;
    endfunction

    task automatic compare(input string tag);
        checks++;
        if (evt_bits !== e_bits || evt_released !== e_rel || evt_strobe !== e_stb) begin
            errors++;
            $display("FAIL %s: actual bits=%02h rel=%0b stb=%0b expected bits=%02h rel=%0b stb=%0b",
                     tag, evt_bits, evt_released, evt_strobe, e_bits, e_rel, e_stb);
        end
    endtask

    // check the result of the previous cycle, then present a new input
    task automatic step(input bit v, input logic [7:0] b, input string tag);
        int ev;
        bit rel;
        @(negedge clk);
        compare(tag);
        code_valid = v;
        code_byte  = b;
        e_stb = 0;
        if (v) begin
            if (b == 8'hE0) begin
                m_ext = 1;
            end else begin
                rel = b[7];
                ev = ref_map(m_ext, b & 'h7F);
                m_ext = 0;
                if (ev != 0 && !(ev >= 'h10 && !rel && ((ev & m_free) == 0))) begin
                    e_bits = ev[7:0];
                    e_rel = rel;
                    e_stb = 1;
                    if (rel) m_free = m_free | ev[7:0];
                    else     m_free = m_free & ~ev[7:0];
                end
            end
        end
    endtask

    task automatic key(input logic [7:0] b, input string tag);
        step(1, b, tag);
        step(0, 8'h00, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare("R1 in reset");
        rst_n = 1;
        step(0, 8'h00, "R1 after reset");
        step(0, 8'h00, "R1 idle");
        // first press of every button strobes (all tracked released)
        key(8'h21, "R1 R5 favourites");
        key(8'h32, "R5 menu");
        key(8'h0F, "R5 volume button");
        key(8'h1C, "R5 navigation button");
        // held button repeat suppressed
        key(8'h21, "R6 repeat favourites");
        key(8'h1C, "R6 repeat navigation button");
        key(8'hA1, "R7 release favourites");
        key(8'h21, "R7 press after release");
        key(8'hA1, "R3 release bit");
        key(8'hA1, "R7 double release");
        // back-to-back bytes
        step(1, 8'hB2, "R8 back to back");
        step(1, 8'h32, "R8 back to back");
        step(1, 8'h32, "R6 back to back repeat");
        step(0, 8'h00, "R8 strobe one cycle");
        step(0, 8'h00, "R8 hold");
        // extended map
        key(8'hE0, "R2 prefix silent");
        key(8'h48, "R4 up");
        key(8'hE0, "R2 prefix");
        key(8'hC8, "R4 R3 up release");
        step(1, 8'hE0, "R2"); step(1, 8'h50, "R4 down");
        step(1, 8'hE0, "R2"); step(1, 8'h4B, "R4 left");
        step(1, 8'hE0, "R2"); step(1, 8'h4D, "R4 right");
        step(1, 8'hE0, "R2"); step(1, 8'hCD, "R4 right release");
        step(0, 8'h00, "R4");
        // wheels never suppressed
        step(1, 8'hE0, "R11"); step(1, 8'h48, "R11 up");
        step(1, 8'hE0, "R11"); step(1, 8'h48, "R11 up again");
        step(1, 8'hE0, "R11"); step(1, 8'h48, "R11 up third");
        step(0, 8'h00, "R11");
        // double prefix keeps extended
        step(1, 8'hE0, "R2"); step(1, 8'hE0, "R2 double prefix");
        step(1, 8'h50, "R2 after double prefix");
        // extended flag clears after unmapped byte
        step(1, 8'hE0, "R9"); step(1, 8'h05, "R9 unmapped ext");
        step(1, 8'h48, "R9 R10 arrow without prefix");
        step(1, 8'hE0, "R10"); step(1, 8'h0F, "R10 button code with prefix");
        step(1, 8'h0F, "R9 plain after ext");
        step(0, 8'h00, "R9");
        key(8'h05, "R10 unmapped plain");
        key(8'h7F, "R10 unmapped plain high");
        key(8'hE0, "R9"); key(8'hB2, "R9 R10 ext button release");
        key(8'hB2, "R7 menu release");
        key(8'h32, "R7 menu press");
        // idle with valid low ignores byte value
        step(0, 8'h21, "R8 valid low ignored");
        step(0, 8'h00, "R8 final");
        step(0, 8'h00, "R8 final");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule